// File: doc/BRIEF.md
# Flash Embedded-Operation Status Generator

This block sits on the device side of a NOR flash. It produces the byte the host sees on the data bus while an embedded program or erase is running. The host polls that byte to learn three things: whether an operation is still running, whether the sector it is reading was picked for erase, and whether the operation failed. When the device is in array-read mode, the block passes stored array data straight through.

The block follows decoded command events and runs its own small state machine. The events are start-program, start-erase, suspend, resume and read/reset. It keeps two toggle registers, each flipped when a host read cycle completes. The first flips while an operation is actively running. The second flips only for reads inside a sector picked for erase, and it keeps doing so while the erase is suspended. A sticky fault bit records two failures: a pulse count that runs past its limit, and an attempt to program a 1 over a stored 0. An erase in which every picked sector is protected erases nothing. In that case the block shows a busy status for a fixed number of cycles and then drops back to array reads.

Top module: `flash_status_gen`

## Requirements
- R1: Out of reset the block is in array-read mode: `dq` equals `arrayData`, `eraseTargets` is 0 and neither toggle bit moves on reads.
- R2: While a program or an active erase runs, `dq[6]` inverts once for each completed read cycle (the cycle after `rdStrobe` falls), whatever `rdSector` is.
- R3: `dq[2]` inverts for each completed read whose `rdSector` lies in the sector set latched at erase start. This holds during an active erase, a suspended erase and the all-protected window. Reads outside that set, and all reads in array or program mode, leave it unchanged.
- R4: If `eraseSel & ~protMask` is zero when start-erase arrives, `eraseTargets` becomes 0 and the status byte is shown for exactly PROT_CYC cycles, with `dq[6]` toggling on reads. After that, `dq` returns to array data.
- R5: On start-erase, `eraseTargets` takes the value `eraseSel & ~protMask`, and it changes at no other time.
- R6: If `pulseCount` exceeds PULSE_LIMIT during a program or an active erase, the block enters the fault state and `dq[5]` reads 1 in the status byte.
- R7: A start-program whose `progData` has a 1 in any bit where `storedData` has a 0 goes directly to the fault state, with `dq[5]`=1.
- R8: The fault state holds `dq[5]`=1 and keeps showing the status byte, with `dq[6]` still toggling. It ignores `opDone`, and only read/reset returns the block to array reads.
- R9: Suspend during an active erase stops `dq[6]`. In suspend, reads outside the erase set return array data. Reads inside it return {1, held dq6, 0, 0, 0, dq2, 0, 0}, with `dq[2]` still toggling. Resume restarts the active erase.
- R10: The status byte is {poll, dq6, fault, 0, 0, dq2, 0, 0}. The poll bit is the inverse of `progData[7]` during a program and 0 during an erase. `opDone` ends a program or an active erase and returns the block to array reads.
- R11: A read/reset command during a program, an active erase, a suspended erase or the all-protected window has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rdStrobe | input | 1 | High while a host read cycle (chip and output enable) is active |
| rdSector | input | SECT_W | Sector index of the read address |
| arrayData | input | 8 | Array content at the read address |
| progData | input | 8 | Byte being programmed |
| storedData | input | 8 | Current array content at the program address |
| eraseSel | input | NSECT | Sectors picked by the erase command |
| protMask | input | NSECT | Protected sectors |
| pulseCount | input | CNT_W | Pulse counter of the embedded algorithm |
| opDone | input | 1 | Embedded algorithm finished (one-cycle pulse) |
| cmdProgram | input | 1 | Start-program event |
| cmdErase | input | 1 | Start-erase event |
| cmdSuspend | input | 1 | Erase-suspend event |
| cmdResume | input | 1 | Erase-resume event |
| cmdReset | input | 1 | Read/reset event |
| dq | output | 8 | Data bus byte: status or array data |
| eraseTargets | output | NSECT | Sectors the erase will actually erase |

## Verification
The assertions take the following for granted about the inputs:
- Each command event is a single-cycle pulse, and at most one event is present in any cycle.
- `rdStrobe` goes low between two read cycles, so every read produces exactly one falling edge.
- `rdSector` always indexes an existing sector.

The stimulus respects all of these. Every command is a one-cycle pulse issued by its own task, and every read holds the strobe high for one cycle and low for at least one cycle. Sector indices are drawn only from the range below NSECT.

// File: rtl/flashstat_pkg.sv
package flashstat_pkg;

  typedef enum logic [2:0] {
    ST_READ,
    ST_PROG,
    ST_ERASE,
    ST_SUSP,
    ST_PROTW,
    ST_FAULT
  } opState_t;

  typedef enum logic [1:0] {
    VIEW_ARRAY,
    VIEW_STATUS,
    VIEW_SUSP
  } view_t;

  typedef struct packed {
    logic  flip6En;
    logic  flip2En;
    logic  loadProg;
    logic  loadErase;
    logic  faultOn;
    view_t view;
  } ctrlStrobe_t;

endpackage

// File: rtl/flashstat_ctrl.sv
module flashstat_ctrl
  import flashstat_pkg::*;
#(
  parameter int CNT_W       = 12,
  parameter int PULSE_LIMIT = 1000,
  parameter int PROT_CYC    = 5000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdProgram,
  input  logic             cmdErase,
  input  logic             cmdSuspend,
  input  logic             cmdResume,
  input  logic             cmdReset,
  input  logic             opDone,
  input  logic [CNT_W-1:0] pulseCount,
  input  logic             progIllegal,
  input  logic             targetsEmpty,
  output ctrlStrobe_t      strb
);

  localparam int PW = $clog2(PROT_CYC + 1);
  localparam logic [PW-1:0] PROT_LAST = PW'(PROT_CYC - 1);

  opState_t        st, stNext;
  logic            faultQ, faultNext;
  logic [PW-1:0]   protCnt, cntNext;
  logic            loadProg, loadErase;
  logic            pulseOver;

  assign pulseOver = pulseCount > CNT_W'(PULSE_LIMIT);

  always_comb begin
    stNext    = st;
    faultNext = faultQ;
    cntNext   = protCnt;
    loadProg  = 1'b0;
    loadErase = 1'b0;
    unique case (st)
      ST_READ: begin
        if (cmdProgram) begin
          loadProg = 1'b1;
          if (progIllegal) begin
            stNext    = ST_FAULT;
            faultNext = 1'b1;
          end else begin
            stNext = ST_PROG;
          end
        end else if (cmdErase) begin
          loadErase = 1'b1;
          cntNext   = '0;
          stNext    = targetsEmpty ? ST_PROTW : ST_ERASE;
        end
      end
      ST_PROG: begin
        if (pulseOver) begin
          stNext    = ST_FAULT;
          faultNext = 1'b1;
        end else if (opDone) begin
          stNext = ST_READ;
        end
      end
      ST_ERASE: begin
        if (pulseOver) begin
          stNext    = ST_FAULT;
          faultNext = 1'b1;
        end else if (opDone) begin
          stNext = ST_READ;
        end else if (cmdSuspend) begin
          stNext = ST_SUSP;
        end
      end
      ST_SUSP: begin
        if (cmdResume) stNext = ST_ERASE;
      end
      ST_PROTW: begin
        if (protCnt == PROT_LAST) stNext = ST_READ;
        else cntNext = protCnt + 1'b1;
      end
      ST_FAULT: begin
        if (cmdReset) begin
          stNext    = ST_READ;
          faultNext = 1'b0;
        end
      end
      default: stNext = ST_READ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st      <= ST_READ;
      faultQ  <= 1'b0;
      protCnt <= '0;
    end else begin
      st      <= stNext;
      faultQ  <= faultNext;
      protCnt <= cntNext;
    end
  end

  always_comb begin
    strb.flip6En   = (st == ST_PROG) || (st == ST_ERASE) || (st == ST_PROTW) || (st == ST_FAULT);
    strb.flip2En   = (st == ST_ERASE) || (st == ST_SUSP) || (st == ST_PROTW);
    strb.loadProg  = loadProg;
    strb.loadErase = loadErase;
    strb.faultOn   = faultQ;
    unique case (st)
      ST_READ: strb.view = VIEW_ARRAY;
      ST_SUSP: strb.view = VIEW_SUSP;
      default: strb.view = VIEW_STATUS;
    endcase
  end

  // R8: fault is released only by read/reset
  assert_fault_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (faultQ && !cmdReset) |=> faultQ);

  // R11: read/reset leaves a running program alone
  assert_reset_ignored_R11: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_PROG && cmdReset && !opDone && !pulseOver) |=> (st == ST_PROG));

  // R4: the all-protected window never outlasts its count
  assert_prot_window_R4: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_PROTW) |-> (protCnt <= PROT_LAST));

endmodule

// File: rtl/flashstat_dp.sv
module flashstat_dp
  import flashstat_pkg::*;
#(
  parameter int NSECT  = 16,
  parameter int SECT_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strb,
  input  logic              rdStrobe,
  input  logic [SECT_W-1:0] rdSector,
  input  logic [7:0]        arrayData,
  input  logic [7:0]        progData,
  input  logic [7:0]        storedData,
  input  logic [NSECT-1:0]  eraseSel,
  input  logic [NSECT-1:0]  protMask,
  output logic [7:0]        dq,
  output logic [NSECT-1:0]  eraseTargets,
  output logic              progIllegal,
  output logic              targetsEmpty
);

  logic             rdPrev, rdFall;
  logic             t6, t2, pollQ;
  logic [NSECT-1:0] selQ, targetsQ;
  logic             selHit;
  logic [7:0]       statusByte, suspByte;

  assign rdFall       = rdPrev && !rdStrobe;
  assign selHit       = selQ[rdSector];
  assign progIllegal  = |(progData & ~storedData);
  assign targetsEmpty = ((eraseSel & ~protMask) == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPrev   <= 1'b0;
      t6       <= 1'b0;
      t2       <= 1'b0;
      pollQ    <= 1'b0;
      selQ     <= '0;
      targetsQ <= '0;
    end else begin
      rdPrev <= rdStrobe;
      if (rdFall && strb.flip6En) t6 <= ~t6;
      if (rdFall && strb.flip2En && selHit) t2 <= ~t2;
      if (strb.loadProg) pollQ <= ~progData[7];
      if (strb.loadErase) begin
        pollQ    <= 1'b0;
        selQ     <= eraseSel;
        targetsQ <= eraseSel & ~protMask;
      end
    end
  end

  assign statusByte = {pollQ, t6, strb.faultOn, 2'b00, t2, 2'b00};
  assign suspByte   = {1'b1, t6, 1'b0, 2'b00, t2, 2'b00};

  always_comb begin
    unique case (strb.view)
      VIEW_STATUS: dq = statusByte;
      VIEW_SUSP:   dq = selHit ? suspByte : arrayData;
      default:     dq = arrayData;
    endcase
  end

  assign eraseTargets = targetsQ;

  // R9: dq6 holds whenever the controller does not allow it to move
  assert_t6_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strb.flip6En |=> $stable(t6));

  // R3: dq2 holds for reads outside the erase set
  assert_t2_unsel_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.flip2En && selHit) |=> $stable(t2));

endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
  import flashstat_pkg::*;
#(
  parameter int NSECT       = 16,
  parameter int CNT_W       = 12,
  parameter int PULSE_LIMIT = 1000,
  parameter int PROT_CYC    = 5000,
  localparam int SECT_W     = (NSECT > 1) ? $clog2(NSECT) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdStrobe,
  input  logic [SECT_W-1:0] rdSector,
  input  logic [7:0]        arrayData,
  input  logic [7:0]        progData,
  input  logic [7:0]        storedData,
  input  logic [NSECT-1:0]  eraseSel,
  input  logic [NSECT-1:0]  protMask,
  input  logic [CNT_W-1:0]  pulseCount,
  input  logic              opDone,
  input  logic              cmdProgram,
  input  logic              cmdErase,
  input  logic              cmdSuspend,
  input  logic              cmdResume,
  input  logic              cmdReset,
  output logic [7:0]        dq,
  output logic [NSECT-1:0]  eraseTargets
);

  ctrlStrobe_t strb;
  logic        progIllegal, targetsEmpty;

  flashstat_ctrl #(
    .CNT_W(CNT_W), .PULSE_LIMIT(PULSE_LIMIT), .PROT_CYC(PROT_CYC)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .cmdProgram(cmdProgram), .cmdErase(cmdErase), .cmdSuspend(cmdSuspend),
    .cmdResume(cmdResume), .cmdReset(cmdReset), .opDone(opDone),
    .pulseCount(pulseCount), .progIllegal(progIllegal),
    .targetsEmpty(targetsEmpty), .strb(strb)
  );

  flashstat_dp #(.NSECT(NSECT), .SECT_W(SECT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .rdStrobe(rdStrobe), .rdSector(rdSector), .arrayData(arrayData),
    .progData(progData), .storedData(storedData),
    .eraseSel(eraseSel), .protMask(protMask),
    .dq(dq), .eraseTargets(eraseTargets),
    .progIllegal(progIllegal), .targetsEmpty(targetsEmpty)
  );

  // R5: erase targets change only after a start-erase event
  assert_targets_stable_R5: assert property (@(posedge clk) disable iff (!rstN)
    !cmdErase |=> $stable(eraseTargets));

  // R1: outside any operation the bus carries array data
  assert_array_view_R1: assert property (@(posedge clk) disable iff (!rstN)
    (strb.view == VIEW_ARRAY) |-> (dq == arrayData));

endmodule

// File: tb/flash_status_gen_tb.sv
module flash_status_gen_tb;

  localparam int NSECT = 16;
  localparam int SW    = 4;
  localparam int CW    = 12;
  localparam int LIM   = 20;
  localparam int PCYC  = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rdStrobe = 1'b0;
  logic [SW-1:0] rdSector = '0;
  logic [7:0] arrayData = 8'h3C, progData = 8'h00, storedData = 8'hFF;
  logic [NSECT-1:0] eraseSel = '0, protMask = '0;
  logic [CW-1:0] pulseCount = '0;
  logic opDone = 0, cmdProgram = 0, cmdErase = 0, cmdSuspend = 0, cmdResume = 0, cmdReset = 0;
  logic [7:0] dq;
  logic [NSECT-1:0] eraseTargets;

  always #10 clk = ~clk;

  flash_status_gen #(.NSECT(NSECT), .CNT_W(CW), .PULSE_LIMIT(LIM), .PROT_CYC(PCYC)) u_dut (
    .clk(clk), .rstN(rstN), .rdStrobe(rdStrobe), .rdSector(rdSector),
    .arrayData(arrayData), .progData(progData), .storedData(storedData),
    .eraseSel(eraseSel), .protMask(protMask), .pulseCount(pulseCount),
    .opDone(opDone), .cmdProgram(cmdProgram), .cmdErase(cmdErase),
    .cmdSuspend(cmdSuspend), .cmdResume(cmdResume), .cmdReset(cmdReset),
    .dq(dq), .eraseTargets(eraseTargets)
  );

  // behavioural reference: 0 read, 1 program, 2 erase, 3 suspended, 4 protected wait, 5 fault
  int mSt = 0;
  int mCnt = 0;
  bit mT6 = 0, mT2 = 0, mPoll = 0, mFault = 0, mPrev = 0;
  logic [NSECT-1:0] mSel = '0, mTgt = '0;
  int compared = 0, mismatched = 0;
  string curReq = "R1";
  bit running = 1;

  always @(posedge clk) begin
    if (!rstN) begin
      mSt = 0; mCnt = 0; mT6 = 0; mT2 = 0; mPoll = 0; mFault = 0; mPrev = 0;
      mSel = '0; mTgt = '0;
    end else begin
      bit fell;
      fell = mPrev && !rdStrobe;
      if (fell && (mSt == 1 || mSt == 2 || mSt == 4 || mSt == 5)) mT6 = !mT6;
      if (fell && (mSt == 2 || mSt == 3 || mSt == 4) && mSel[rdSector]) mT2 = !mT2;
      mPrev = rdStrobe;
      case (mSt)
        0: if (cmdProgram) begin
             mPoll = !progData[7];
             if ((progData & ~storedData) != 0) begin mSt = 5; mFault = 1; end
             else mSt = 1;
           end else if (cmdErase) begin
             mPoll = 0; mSel = eraseSel; mTgt = eraseSel & ~protMask; mCnt = 0;
             mSt = (mTgt == 0) ? 4 : 2;
           end
        1: if (int'(pulseCount) > LIM) begin mSt = 5; mFault = 1; end
           else if (opDone) mSt = 0;
        2: if (int'(pulseCount) > LIM) begin mSt = 5; mFault = 1; end
           else if (opDone) mSt = 0;
           else if (cmdSuspend) mSt = 3;
        3: if (cmdResume) mSt = 2;
        4: if (mCnt == PCYC - 1) mSt = 0; else mCnt++;
        5: if (cmdReset) begin mSt = 0; mFault = 0; end
        default: mSt = 0;
      endcase
    end
  end

  function automatic logic [7:0] expDq();
    case (mSt)
      0: return arrayData;
      3: return mSel[rdSector] ? {1'b1, mT6, 1'b0, 2'b00, mT2, 2'b00} : arrayData;
      default: return {mPoll, mT6, mFault, 2'b00, mT2, 2'b00};
    endcase
  endfunction

  always @(negedge clk) begin
    #5;
    if (running) begin
      compared++;
      if (dq !== expDq()) begin
        mismatched++;
        $display("FAIL %s dq actual=%h expected=%h t=%0t", curReq, dq, expDq(), $time);
      end
      compared++;
      if (eraseTargets !== mTgt) begin
        mismatched++;
        $display("FAIL %s eraseTargets actual=%h expected=%h t=%0t", curReq, eraseTargets, mTgt, $time);
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic readAt(int s);
    @(negedge clk); rdStrobe = 1; rdSector = SW'(s);
    @(negedge clk); rdStrobe = 0;
  endtask

  task automatic pulseProgram(); @(negedge clk); cmdProgram = 1; @(negedge clk); cmdProgram = 0; endtask
  task automatic pulseErase();   @(negedge clk); cmdErase = 1;   @(negedge clk); cmdErase = 0;   endtask
  task automatic pulseSuspend(); @(negedge clk); cmdSuspend = 1; @(negedge clk); cmdSuspend = 0; endtask
  task automatic pulseResume();  @(negedge clk); cmdResume = 1;  @(negedge clk); cmdResume = 0;  endtask
  task automatic pulseReset();   @(negedge clk); cmdReset = 1;   @(negedge clk); cmdReset = 0;   endtask
  task automatic pulseDone();    @(negedge clk); opDone = 1;     @(negedge clk); opDone = 0;     endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (running) begin
      running = 0;
      mismatched++;
      $display("FAIL watchdog expired during %s", curReq);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    curReq = "R1";
    idle(3);
    rstN = 1;
    idle(2);
    for (int i = 0; i < 4; i++) begin arrayData = 8'(8'h11 * i); readAt(i); end

    curReq = "R2";
    progData = 8'h5A; storedData = 8'hFF;
    pulseProgram();
    for (int i = 0; i < 5; i++) readAt(i * 3);
    curReq = "R11";
    pulseReset();
    readAt(7);
    curReq = "R10";
    pulseDone();
    arrayData = 8'hA5; readAt(2);
    progData = 8'hC3; storedData = 8'hFF;
    pulseProgram(); readAt(1); pulseDone();

    curReq = "R5";
    eraseSel = 16'h00F0; protMask = 16'h0030;
    pulseErase();
    curReq = "R3";
    readAt(5); readAt(6); readAt(1); readAt(12); readAt(7);
    curReq = "R9";
    pulseSuspend();
    arrayData = 8'h77;
    readAt(5); readAt(2); readAt(7); readAt(9);
    curReq = "R11";
    pulseReset();
    readAt(4);
    curReq = "R9";
    pulseResume();
    readAt(4); readAt(0);
    curReq = "R10";
    pulseDone();
    readAt(5);

    curReq = "R4";
    eraseSel = 16'h0300; protMask = 16'h0F00;
    pulseErase();
    readAt(8); readAt(1); readAt(9);
    idle(PCYC);
    readAt(8);

    curReq = "R6";
    eraseSel = 16'h8001; protMask = 16'h0000;
    pulseErase();
    readAt(15);
    @(negedge clk); pulseCount = CW'(LIM + 1);
    @(negedge clk); pulseCount = '0;
    curReq = "R8";
    readAt(0); pulseDone(); readAt(3); idle(2);
    pulseReset();
    readAt(0);

    curReq = "R7";
    progData = 8'h1F; storedData = 8'h0F;
    pulseProgram();
    readAt(2); readAt(3);
    curReq = "R8";
    pulseDone(); readAt(4);
    pulseReset();
    readAt(4);

    curReq = "R6";
    progData = 8'h01; storedData = 8'hFF;
    pulseProgram();
    @(negedge clk); pulseCount = CW'(LIM);
    readAt(6);
    @(negedge clk); pulseCount = CW'(LIM + 3);
    @(negedge clk); pulseCount = '0;
    readAt(6);
    pulseReset();
    idle(3);

    running = 0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule